// File: doc/BRIEF.md
# Oversampled Serial Receiver with Echo

This block receives asynchronous serial characters on a single input line. A one-cycle sample tick, sixteen of which make up one bit time, times the receiver. Either an internal rate source or an external receive clock supplies the tick, and a select input chooses between them. The block synchronises the line and finds the falling edge of the start bit. It samples every bit once, at the middle of its period, and builds the character least significant bit first.

Four word lengths and several parity options are set by configuration inputs. A start bit that is gone by mid-bit is dropped as noise. The finished character is held right-justified with its upper bits cleared, next to parity, framing and overrun flags, until the host pulses a read strobe.

The receiver runs only while the modem reports ready and the host enables the terminal-ready control. An echo option routes the synchronised receive line onto the transmit line in place of the normal transmitter output.

Top module: `serial_rx_echo`

## Requirements
- R1: After reset, rx_full, err_parity, err_frame and err_overrun are 0, rx_data is 0, and txd_out follows tx_line_in while echo is off.
- R2: Bits are taken least significant first. cfg_len selects the word length: 2'b00 = 8, 2'b01 = 7, 2'b10 = 6, 2'b11 = 5 bits. Every rx_data bit above the word length reads 0.
- R3: cfg_par bit 0 = 1 means a parity bit follows the data. Bits 2:1 then give the mode: 00 odd, 01 even (both checked and reported on err_parity), 10 mark and 11 space (the bit is consumed but never checked). The parity bit never appears in rx_data, and err_parity changes only when a character is accepted.
- R4: A start bit sampled high at its mid-bit sample is discarded: the receiver returns to idle and no character is produced.
- R5: A low level at the stop-bit mid sample sets err_frame, and the character is still delivered with rx_full set.
- R6: A character that completes while rx_full is 1 and no read is pulsed sets err_overrun. It keeps the earlier rx_data and drops the new character. The next accepted character clears err_overrun. rd_strobe clears rx_full.
- R7: The receiver stays idle and accepts nothing unless dtr_en is 1 and dsr_n is 0.
- R8: clk_src_int = 1 takes sample ticks from tick_int, and 0 takes them from tick_ext. The unselected tick has no effect.
- R9: When echo_en is 1 and tx_mode is 2'b00, txd_out equals rxd_in delayed by the two synchroniser stages. In every other case txd_out equals tx_line_in.
- R10: Each bit is sampled on the 8th tick after the previous 16-tick boundary, counted from the tick that saw the start edge. A character reaches rx_full one clock after its stop-bit sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | 16x sample tick from the internal rate source |
| tick_ext | input | 1 | 16x sample tick from the external receive clock |
| clk_src_int | input | 1 | 1 selects tick_int, 0 selects tick_ext |
| rxd_in | input | 1 | Serial receive line, idle high |
| dsr_n | input | 1 | Modem ready, active low |
| dtr_en | input | 1 | Terminal-ready enable for the receiver |
| cfg_len | input | 2 | Word length code |
| cfg_par | input | 3 | Parity mode field |
| echo_en | input | 1 | Echo request |
| tx_mode | input | 2 | Transmit control field; echo is valid only at 00 |
| tx_line_in | input | 1 | Line from the normal transmitter |
| rd_strobe | input | 1 | Host read of the received character |
| rx_data | output | DATA_W | Received character, right-justified |
| rx_full | output | 1 | Character waiting |
| err_parity | output | 1 | Parity error of the held character |
| err_frame | output | 1 | Framing error of the held character |
| err_overrun | output | 1 | A character was lost |
| txd_out | output | 1 | Transmit line (echo or transmitter) |

## Verification
The bench uses the default parameters: DATA_W = 8, OVERSAMPLE = 16, SYNC_STAGES = 2, with the external tick path built in. The internal tick fires every 4 clocks (64 clocks per bit) and the external one every 5 clocks (80 clocks per bit). At these rates a full character takes under a thousand cycles, so all four word lengths, every parity mode, both tick sources, framing errors, overrun, noise starts, gating and echo fit in one short run. Because the two tick sources run at different periods, a character sent at the wrong rate shows up as a wrong or missing result.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_t;

   localparam int PAR_ENABLE_BIT = 0;
   localparam int PAR_EVEN_BIT   = 1;
   localparam int PAR_NOCHK_BIT  = 2;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= RESET_VAL;
            else        pipe <= d;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= {STAGES{RESET_VAL}};
            else        pipe <= {pipe[STAGES-2:0], d};
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_tick_sel.sv
module srx_tick_sel #(
   parameter bit HAS_EXT_TICK = 1'b1
) (
   input  logic tick_int,
   input  logic tick_ext,
   input  logic use_int,
   output logic tick
);
   generate
      if (HAS_EXT_TICK) begin : g_mux
         assign tick = use_int ? tick_int : tick_ext;
      end else begin : g_int_only
         logic unused_sel;
         assign unused_sel = tick_ext ^ use_int;
         assign tick = tick_int;
      end
   endgenerate
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_on,
   input  logic              tick,
   input  logic              rxd,
   input  logic [1:0]        cfg_len,
   input  logic [2:0]        cfg_par,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              par_bad,
   output logic              stop_bad
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_W);
   localparam int MID   = OVERSAMPLE / 2 - 1;
   localparam int LAST  = OVERSAMPLE - 1;

   rx_state_t        st;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] last_idx;
   logic             par_bit;
   logic             at_mid;
   logic             at_end;

   assign at_mid   = (cnt == CNT_W'(MID));
   assign at_end   = (cnt == CNT_W'(LAST));
   assign last_idx = IDX_W'(DATA_W - 1) - IDX_W'(cfg_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         idx      <= '0;
         data     <= '0;
         par_bit  <= 1'b0;
         stop_bad <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!rx_on) begin
            st <= ST_IDLE;
         end else if (tick) begin
            cnt <= cnt + 1'b1;
            unique case (st)
               ST_IDLE: begin
                  if (!rxd) begin
                     st   <= ST_START;
                     cnt  <= '0;
                     idx  <= '0;
                     data <= '0;
                  end
               end
               ST_START: begin
                  if (at_mid && rxd) st <= ST_IDLE;
                  else if (at_end)   st <= ST_DATA;
               end
               ST_DATA: begin
                  if (at_mid) data[idx] <= rxd;
                  if (at_end) begin
                     if (idx == last_idx) begin
                        idx <= '0;
                        st  <= cfg_par[PAR_ENABLE_BIT] ? ST_PAR : ST_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end
               end
               ST_PAR: begin
                  if (at_mid) par_bit <= rxd;
                  if (at_end) st <= ST_STOP;
               end
               ST_STOP: begin
                  if (at_mid) begin
                     done     <= 1'b1;
                     stop_bad <= !rxd;
                     st       <= ST_IDLE;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign par_bad = cfg_par[PAR_ENABLE_BIT] && !cfg_par[PAR_NOCHK_BIT] &&
                    ((^data ^ par_bit) == cfg_par[PAR_EVEN_BIT]);
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_pe,
   input  logic              in_fe,
   input  logic              rd,
   output logic [DATA_W-1:0] out_data,
   output logic              full,
   output logic              pe,
   output logic              fe,
   output logic              ovr
);
   logic room;
   assign room = !full || rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data <= '0;
         full     <= 1'b0;
         pe       <= 1'b0;
         fe       <= 1'b0;
         ovr      <= 1'b0;
      end else if (accept && room) begin
         out_data <= in_data;
         pe       <= in_pe;
         fe       <= in_fe;
         ovr      <= 1'b0;
         full     <= 1'b1;
      end else if (accept) begin
         ovr      <= 1'b1;
      end else if (rd) begin
         full     <= 1'b0;
      end
   end
endmodule

// File: rtl/serial_rx_echo.sv
module serial_rx_echo #(
   parameter int DATA_W       = 8,
   parameter int OVERSAMPLE   = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_EXT_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_int,
   input  logic              tick_ext,
   input  logic              clk_src_int,
   input  logic              rxd_in,
   input  logic              dsr_n,
   input  logic              dtr_en,
   input  logic [1:0]        cfg_len,
   input  logic [2:0]        cfg_par,
   input  logic              echo_en,
   input  logic [1:0]        tx_mode,
   input  logic              tx_line_in,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun,
   output logic              txd_out
);
   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4 so every length code is legal");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rxd_s;
   logic              tick;
   logic              rx_on;
   logic              f_done;
   logic [DATA_W-1:0] f_data;
   logic              f_pe;
   logic              f_fe;
   logic              echo_active;

   assign rx_on = dtr_en && !dsr_n;

   srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd_in),
      .q     (rxd_s)
   );

   srx_tick_sel #(.HAS_EXT_TICK(HAS_EXT_TICK)) u_tick (
      .tick_int (tick_int),
      .tick_ext (tick_ext),
      .use_int  (clk_src_int),
      .tick     (tick)
   );

   srx_frame #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_on    (rx_on),
      .tick     (tick),
      .rxd      (rxd_s),
      .cfg_len  (cfg_len),
      .cfg_par  (cfg_par),
      .done     (f_done),
      .data     (f_data),
      .par_bad  (f_pe),
      .stop_bad (f_fe)
   );

   srx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (f_done && rx_on),
      .in_data  (f_data),
      .in_pe    (f_pe),
      .in_fe    (f_fe),
      .rd       (rd_strobe),
      .out_data (rx_data),
      .full     (rx_full),
      .pe       (err_parity),
      .fe       (err_frame),
      .ovr      (err_overrun)
   );

   assign echo_active = echo_en && (tx_mode == 2'b00);
   assign txd_out     = echo_active ? rxd_s : tx_line_in;
endmodule

// File: rtl/serial_rx_echo_chk.sv
module serial_rx_echo_chk #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rxd_in,
   input logic              dsr_n,
   input logic              dtr_en,
   input logic [1:0]        cfg_len,
   input logic              rd_strobe,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              err_parity,
   input logic              err_frame,
   input logic              echo_en,
   input logic [1:0]        tx_mode,
   input logic              txd_out
);
   // R2: a freshly accepted character has nothing above its word length
   p_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> ((rx_data >> (DATA_W - int'(cfg_len))) == '0));

   // R3: the parity flag moves only together with a held character
   p_par_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_parity) |-> rx_full);

   // R5: a framing error comes with the character delivered
   p_frame_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_frame) |-> rx_full);

   // R6: an unread character is kept intact until read
   p_keep_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rd_strobe) |=> (rx_full && $stable(rx_data)));

   // R7: nothing is accepted while the receiver is gated off
   p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(dtr_en && !dsr_n) |=> !$rose(rx_full));

   generate
      if (SYNC_STAGES == 2) begin : g_echo_chk
         // R9: echo copies the line after the two synchroniser stages
         p_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (echo_en && tx_mode == 2'b00 && $past(rst_n) && $past(rst_n, 2))
               |-> (txd_out == $past(rxd_in, 2)));
      end
   endgenerate
endmodule

bind serial_rx_echo serial_rx_echo_chk #(
   .DATA_W      (DATA_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rxd_in     (rxd_in),
   .dsr_n      (dsr_n),
   .dtr_en     (dtr_en),
   .cfg_len    (cfg_len),
   .rd_strobe  (rd_strobe),
   .rx_data    (rx_data),
   .rx_full    (rx_full),
   .err_parity (err_parity),
   .err_frame  (err_frame),
   .echo_en    (echo_en),
   .tx_mode    (tx_mode),
   .txd_out    (txd_out)
);

// File: tb/sim_serial_rx_echo.sv
`timescale 1ns/1ps
module sim_serial_rx_echo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_int = 1'b0;
   logic       tick_ext = 1'b0;
   logic       clk_src_int = 1'b1;
   logic       rxd_in = 1'b1;
   logic       dsr_n = 1'b0;
   logic       dtr_en = 1'b1;
   logic [1:0] cfg_len = 2'b00;
   logic [2:0] cfg_par = 3'b000;
   logic       echo_en = 1'b0;
   logic [1:0] tx_mode = 2'b01;
   logic       tx_line_in = 1'b1;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, err_parity, err_frame, err_overrun, txd_out;

   int total = 0;
   int bad   = 0;
   bit chk_on = 1'b0;
   bit ext_run = 1'b1;
   int tcnt = 0;

   always #2.5 clk = ~clk;

   serial_rx_echo u0 (
      .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
      .clk_src_int(clk_src_int), .rxd_in(rxd_in), .dsr_n(dsr_n), .dtr_en(dtr_en),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .echo_en(echo_en), .tx_mode(tx_mode),
      .tx_line_in(tx_line_in), .rd_strobe(rd_strobe), .rx_data(rx_data),
      .rx_full(rx_full), .err_parity(err_parity), .err_frame(err_frame),
      .err_overrun(err_overrun), .txd_out(txd_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // tick sources: internal every 4 clocks, external every 5
   initial begin
      forever begin
         step();
         tcnt++;
         tick_int = (tcnt % 4 == 0);
         tick_ext = ext_run && (tcnt % 5 == 0);
      end
   end

   // ---------------- behavioural reference model ----------------
   int         ms1 = 1, ms2 = 1;
   int         mst = 0, mcnt = 0, midx = 0;
   logic [7:0] mbuf = 8'h00;
   int         mpbit = 0, mdone = 0, mstopbad = 0;
   int         mq = 0, mfull = 0, mpe = 0, mfe = 0, movr = 0;

   always @(posedge clk) begin
      int rxd, tk, on, nb, ones;
      if (!rst_n) begin
         ms1 = 1; ms2 = 1; mst = 0; mcnt = 0; midx = 0; mbuf = 8'h00;
         mpbit = 0; mdone = 0; mstopbad = 0;
         mq = 0; mfull = 0; mpe = 0; mfe = 0; movr = 0;
      end else begin
         rxd = ms2;
         tk  = clk_src_int ? int'(tick_int) : int'(tick_ext);
         on  = (dtr_en && !dsr_n) ? 1 : 0;
         nb  = 8 - int'(cfg_len);
         if (mdone != 0 && on != 0) begin
            if (mfull != 0 && !rd_strobe) movr = 1;
            else begin
               ones = $countones(mbuf) + mpbit;
               mq = int'(mbuf);
               mpe = (cfg_par[0] && !cfg_par[2] && ((ones % 2) == int'(cfg_par[1]))) ? 1 : 0;
               mfe = mstopbad; movr = 0; mfull = 1;
            end
         end else if (rd_strobe) mfull = 0;
         mdone = 0;
         if (on == 0) mst = 0;
         else if (tk != 0) begin
            case (mst)
               0: if (rxd == 0) begin mst = 1; mcnt = 0; midx = 0; mbuf = 8'h00; end
               1: begin
                  if (mcnt == 7 && rxd != 0) mst = 0;
                  else if (mcnt == 15) mst = 2;
                  mcnt = (mcnt + 1) % 16;
               end
               2: begin
                  if (mcnt == 7) mbuf[midx] = rxd[0];
                  if (mcnt == 15) begin
                     if (midx == nb - 1) begin midx = 0; mst = cfg_par[0] ? 3 : 4; end
                     else midx++;
                  end
                  mcnt = (mcnt + 1) % 16;
               end
               3: begin
                  if (mcnt == 7) mpbit = rxd;
                  if (mcnt == 15) mst = 4;
                  mcnt = (mcnt + 1) % 16;
               end
               default: begin
                  if (mcnt == 7) begin mdone = 1; mstopbad = (rxd == 0) ? 1 : 0; mst = 0; end
                  mcnt = (mcnt + 1) % 16;
               end
            endcase
         end
         ms2 = ms1;
         ms1 = int'(rxd_in);
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (chk_on) begin
         chk("R2 rx_data vs model", int'(rx_data), mq);
         chk("R10 rx_full vs model", int'(rx_full), mfull);
         chk("R3 err_parity vs model", int'(err_parity), mpe);
         chk("R5 err_frame vs model", int'(err_frame), mfe);
         chk("R6 err_overrun vs model", int'(err_overrun), movr);
         chk("R9 txd_out vs model", int'(txd_out),
             (echo_en && tx_mode == 2'b00) ? ms2 : int'(tx_line_in));
      end
   end

   // ---------------- stimulus ----------------
   task automatic line(input bit b, input int n);
      rxd_in = b;
      repeat (n) step();
   endtask

   task automatic send_char(input int val, input int nb, input bit has_p, input bit pb,
                            input bit stop_ok, input int per);
      line(1'b0, per);
      for (int i = 0; i < nb; i++) line(1'((val >> i) & 1), per);
      if (has_p) line(pb, per);
      if (stop_ok) line(1'b1, per);
      else begin
         line(1'b0, per * 11 / 16);
         line(1'b1, per - per * 11 / 16);
      end
      line(1'b1, 2 * per);
   endtask

   task automatic do_read();
      rd_strobe = 1'b1;
      step();
      rd_strobe = 1'b0;
      step();
   endtask

   task automatic check_char(input string req, input int data, input int pe,
                             input int fe, input int ovr);
      @(negedge clk);
      chk({req, " full"}, int'(rx_full), 1);
      chk({req, " data"}, int'(rx_data), data);
      chk({req, " parity flag"}, int'(err_parity), pe);
      chk({req, " frame flag"}, int'(err_frame), fe);
      chk({req, " overrun flag"}, int'(err_overrun), ovr);
      step();
   endtask

   task automatic run_all();
      repeat (5) step();
      rst_n = 1'b1;
      step();
      chk_on = 1'b1;
      @(negedge clk);
      chk("R1 reset rx_full", int'(rx_full), 0);
      chk("R1 reset rx_data", int'(rx_data), 0);
      chk("R1 reset flags", int'({err_parity, err_frame, err_overrun}), 0);
      chk("R1 reset txd_out high", int'(txd_out), 1);
      step();
      tx_line_in = 1'b0;
      @(negedge clk);
      chk("R1 txd_out follows transmitter", int'(txd_out), 0);
      step();
      tx_line_in = 1'b1;

      // R2: 8 bits, no parity
      send_char(8'hA5, 8, 0, 0, 1, 64);
      check_char("R2 8N1", 8'hA5, 0, 0, 0);
      do_read();

      // R2/R3: 7 bits, even parity, correct parity bit, top bit dropped
      cfg_len = 2'b01; cfg_par = 3'b011; step();
      send_char(8'hDB, 7, 1, 1, 1, 64);
      check_char("R3 7E good", 8'h5B, 0, 0, 0);
      do_read();

      // R3: 5 bits, odd parity, wrong parity bit
      cfg_len = 2'b11; cfg_par = 3'b001; step();
      send_char(8'hF6, 5, 1, 1, 1, 64);
      check_char("R3 5O bad parity", 8'h16, 1, 0, 0);
      do_read();

      // R3: 6 bits, mark mode, parity bit not checked
      cfg_len = 2'b10; cfg_par = 3'b101; step();
      send_char(8'hEA, 6, 1, 0, 1, 64);
      check_char("R3 6 mark unchecked", 8'h2A, 0, 0, 0);
      do_read();

      // R5: 8 bits, stop sampled low
      cfg_len = 2'b00; cfg_par = 3'b000; step();
      send_char(8'h81, 8, 0, 0, 0, 64);
      check_char("R5 framing", 8'h81, 0, 1, 0);
      do_read();
      line(1'b1, 200);
      @(negedge clk);
      chk("R4 no spurious char after framing", int'(rx_full), 0);
      step();

      // R6: overrun keeps first byte
      send_char(8'h11, 8, 0, 0, 1, 64);
      check_char("R6 first", 8'h11, 0, 0, 0);
      send_char(8'h22, 8, 0, 0, 1, 64);
      check_char("R6 overrun", 8'h11, 0, 0, 1);
      do_read();
      send_char(8'h33, 8, 0, 0, 1, 64);
      check_char("R6 overrun cleared", 8'h33, 0, 0, 0);
      do_read();

      // R4: short low glitch is a false start
      line(1'b0, 16);
      line(1'b1, 200);
      @(negedge clk);
      chk("R4 false start dropped", int'(rx_full), 0);
      step();

      // R7: gating by modem ready and terminal-ready enable
      dsr_n = 1'b1; step();
      send_char(8'h66, 8, 0, 0, 1, 64);
      @(negedge clk);
      chk("R7 dsr_n high blocks", int'(rx_full), 0);
      step();
      dsr_n = 1'b0; dtr_en = 1'b0; step();
      send_char(8'h77, 8, 0, 0, 1, 64);
      @(negedge clk);
      chk("R7 dtr_en low blocks", int'(rx_full), 0);
      step();
      dtr_en = 1'b1; step();

      // R8: external tick source
      clk_src_int = 1'b0; step();
      send_char(8'h3C, 8, 0, 0, 1, 80);
      check_char("R8 external tick", 8'h3C, 0, 0, 0);
      do_read();
      ext_run = 1'b0; step();
      send_char(8'h55, 8, 0, 0, 1, 64);
      @(negedge clk);
      chk("R8 internal tick ignored", int'(rx_full), 0);
      step();
      ext_run = 1'b1; clk_src_int = 1'b1; step();

      // R9: echo
      dtr_en = 1'b0; echo_en = 1'b1; tx_mode = 2'b00; tx_line_in = 1'b1; step();
      rxd_in = 1'b0;
      repeat (3) step();
      @(negedge clk);
      chk("R9 echo copies line", int'(txd_out), 0);
      step();
      tx_mode = 2'b01;
      @(negedge clk);
      chk("R9 echo invalid with tx_mode 01", int'(txd_out), 1);
      step();
      rxd_in = 1'b1; echo_en = 1'b0; dtr_en = 1'b1;
      repeat (4) step();

      // R10: final 8-bit character after all mode changes
      send_char(8'hC3, 8, 0, 0, 1, 64);
      check_char("R10 last", 8'hC3, 0, 0, 0);
      do_read();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            total++; bad++;
            $display("FAIL R10 watchdog actual=hang expected=finish");
         end
      join_any
      chk_on = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule